// File: doc/BRIEF.md
# Three-Wire Serial Slave Port

This block is the serial slave side of a timekeeping device. A host talks to it over three pins: an enable line that frames each transfer, a serial clock, and a data line whose input and output halves are kept apart. The output half has its own enable. The block runs on a fast system clock and oversamples the three pins through synchronizers. Every transfer opens with a command byte. That byte says whether the transfer reads or writes, whether it goes to clock registers or to user RAM, and which index it starts at.

After the command byte the block either takes write bytes from the host or drives read bytes back to it. It reaches the storage through a plain register port. That port has a write strobe, a read strobe, a 6-bit address and byte-wide data. Read data comes back one system cycle after the read strobe. When the index field is all ones, the transfer is a burst: it walks the whole clock bank (8 entries) or the whole RAM bank (31 entries) from index 0. Lowering the enable line ends the transfer at once, releases the data line, and throws away any byte that is only partly received. The host must keep each serial clock half period at least 4 system cycles long, and must raise the enable line only while the serial clock is low.

Top module: `tws_slave`

## Requirements
- R1: While reset is held and after it is released with the enable line low, `sdio_oe`, `reg_we` and `reg_re` are all 0.
- R2: The first 8 rising serial clock edges after the enable line goes high shift in a command byte, least significant bit first. In that byte, bit 0 is 1 for read and 0 for write, bits 5:1 are the index, bit 6 is 1 for RAM and 0 for clock registers, and bit 7 marks the command valid. The storage address is {bit 6, bits 5:1}.
- R3: A command with bit 7 equal to 0 is ignored for the rest of the transfer: no write or read strobe, and `sdio_oe` stays 0.
- R4: A single write takes 8 data bits, least significant bit first, on the rising edges after the command. It then gives exactly one `reg_we` pulse carrying the command's address and that byte.
- R5: A single read gives `reg_re` for the command's address. It then drives the returned byte least significant bit first, with one bit per falling serial clock edge, starting at the falling edge that ends the command. `sdio_oe` is 1 from that edge until the falling edge after the eighth data bit, where it returns to 0.
- R6: Index 31 with bit 6 equal to 0 is a clock burst. It writes or reads clock indices 0 to 7 in order, and it ignores any further bytes.
- R7: Index 31 with bit 6 equal to 1 is a RAM burst over RAM indices 0 to 30 in order. A RAM address with index 31 never reaches the storage port.
- R8: When the enable line goes low, `sdio_oe` goes to 0 in the same instant, and a byte that is only partly received is never written.
- R9: `sdio_o` changes only after a falling serial clock edge, so it stays stable while the serial clock is high.
- R10: Each completed write byte gives exactly one single-cycle `reg_we` pulse, and `reg_we` and `reg_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | Transfer enable from host, high frames a transfer |
| sclk_i | input | 1 | Serial clock from host |
| sdio_i | input | 1 | Serial data from host |
| sdio_o | output | 1 | Serial data toward host |
| sdio_oe | output | 1 | Output enable for the data line |
| reg_we | output | 1 | Storage write strobe |
| reg_re | output | 1 | Storage read strobe |
| reg_addr | output | 6 | Storage address, bit 5 selects RAM, bits 4:0 index |
| reg_wdata | output | 8 | Storage write data |
| reg_rdata | input | 8 | Storage read data, valid one cycle after `reg_re` |

## Verification
A serial clock edge at a pin becomes a storage strobe or a new `sdio_o` bit on the third system clock edge after it. That is two synchronizer stages plus the edge-detect register. `sdio_oe` drops with no delay when the enable line falls. The bench waits six system cycles after each serial edge before it samples data or storage. This places every check past the three-cycle latency and before the next serial edge. The abort check samples one time unit after the enable line falls, because that path has no clock in it.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 5;
  localparam int ADDR_W = IDX_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WR,
    ST_RD,
    ST_HOLD
  } tws_state_e;

  typedef struct packed {
    logic             valid;
    logic             ram;
    logic [IDX_W-1:0] idx;
    logic             rd;
  } tws_cmd_t;

  function automatic tws_cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
    tws_cmd_t c;
    c.valid = b[7];
    c.ram   = b[6];
    c.idx   = b[5:1];
    c.rd    = b[0];
    return c;
  endfunction
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tws_shifter.sv
module tws_shifter import tws_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic              din,
  input  logic              load,
  input  logic              shift,
  input  logic [BYTE_W-1:0] load_val,
  output logic [BYTE_W-1:0] rx_next,
  output logic              dout
);
  logic [BYTE_W-1:0] rx_q;
  logic [BYTE_W-1:0] tx_q;

  // LSB first: each new bit enters at the top and moves down
  assign rx_next = {din, rx_q[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q <= '0;
    end else if (rise) begin
      rx_q <= rx_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
      dout <= 1'b0;
    end else if (load) begin
      dout <= load_val[0];
      tx_q <= load_val >> 1;
    end else if (shift) begin
      dout <= tx_q[0];
      tx_q <= tx_q >> 1;
    end
  end
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl import tws_pkg::*; #(
  parameter int CLK_REGS  = 8,
  parameter int RAM_BYTES = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_s,
  input  logic              rise,
  input  logic              fall,
  input  logic [BYTE_W-1:0] rx_next,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              tx_load,
  output logic              tx_shift,
  output logic [BYTE_W-1:0] tx_val,
  output logic              drive,
  output logic              reg_we,
  output logic              reg_re,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata
);
  localparam logic [IDX_W-1:0] BURST_IDX = '1;
  localparam logic [IDX_W-1:0] CLK_LAST  = IDX_W'(CLK_REGS - 1);
  localparam logic [IDX_W-1:0] RAM_LAST  = IDX_W'(RAM_BYTES - 1);

  tws_state_e        state;
  logic [3:0]        bcnt;
  logic              ram_q;
  logic              burst_q;
  logic              more_q;
  logic [IDX_W-1:0]  idx_q;
  logic              re_d;
  logic [BYTE_W-1:0] rd_buf;

  tws_cmd_t          cmd;
  logic              cmd_burst;
  logic [IDX_W-1:0]  cmd_start;
  logic              last_idx;
  logic [IDX_W-1:0]  idx_nxt;

  always_comb begin
    cmd       = decode_cmd(rx_next);
    cmd_burst = (cmd.idx == BURST_IDX);
    cmd_start = cmd_burst ? '0 : cmd.idx;
    last_idx  = burst_q ? (idx_q == (ram_q ? RAM_LAST : CLK_LAST)) : 1'b1;
    idx_nxt   = idx_q + 1'b1;
  end

  assign tx_load  = (state == ST_RD) && fall &&
                    ((bcnt == 4'd0) || ((bcnt == 4'd8) && more_q));
  assign tx_shift = (state == ST_RD) && fall &&
                    (bcnt >= 4'd1) && (bcnt <= 4'd7);
  assign tx_val   = rd_buf;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bcnt      <= '0;
      ram_q     <= 1'b0;
      burst_q   <= 1'b0;
      more_q    <= 1'b0;
      idx_q     <= '0;
      drive     <= 1'b0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else if (!ce_s) begin
      state  <= ST_IDLE;
      bcnt   <= '0;
      more_q <= 1'b0;
      drive  <= 1'b0;
      reg_we <= 1'b0;
      reg_re <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          state <= ST_CMD;
          bcnt  <= '0;
        end
        ST_CMD: begin
          if (rise) begin
            if (bcnt == 4'd7) begin
              bcnt <= '0;
              if (!cmd.valid) begin
                state <= ST_HOLD;
              end else begin
                ram_q   <= cmd.ram;
                burst_q <= cmd_burst;
                idx_q   <= cmd_start;
                if (cmd.rd) begin
                  reg_re   <= 1'b1;
                  reg_addr <= {cmd.ram, cmd_start};
                  state    <= ST_RD;
                end else begin
                  state <= ST_WR;
                end
              end
            end else begin
              bcnt <= bcnt + 4'd1;
            end
          end
        end
        ST_WR: begin
          if (rise) begin
            if (bcnt == 4'd7) begin
              bcnt      <= '0;
              reg_we    <= 1'b1;
              reg_addr  <= {ram_q, idx_q};
              reg_wdata <= rx_next;
              if (last_idx) state <= ST_HOLD;
              else          idx_q <= idx_nxt;
            end else begin
              bcnt <= bcnt + 4'd1;
            end
          end
        end
        ST_RD: begin
          if (tx_load) begin
            drive  <= 1'b1;
            bcnt   <= 4'd1;
            more_q <= !last_idx;
            if (!last_idx) begin
              idx_q    <= idx_nxt;
              reg_re   <= 1'b1;
              reg_addr <= {ram_q, idx_nxt};
            end
          end else if (tx_shift) begin
            bcnt <= bcnt + 4'd1;
          end else if (fall && (bcnt == 4'd8)) begin
            drive <= 1'b0;
            state <= ST_HOLD;
          end
        end
        default: ;
      endcase
    end
  end

  // read return path: one-cycle storage latency, captured for the next load
  always_ff @(posedge clk) begin
    if (rst) begin
      re_d   <= 1'b0;
      rd_buf <= '0;
    end else begin
      re_d <= reg_re;
      if (re_d) rd_buf <= reg_rdata;
    end
  end
endmodule

// File: rtl/tws_slave.sv
module tws_slave import tws_pkg::*; #(
  parameter int CLK_REGS    = 8,
  parameter int RAM_BYTES   = 31,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_i,
  input  logic              sclk_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic              reg_we,
  output logic              reg_re,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic [2:0]        pin_s;
  logic              ce_s;
  logic              sclk_s;
  logic              din_s;
  logic              sclk_d;
  logic              sclk_rise;
  logic              sclk_fall;
  logic [BYTE_W-1:0] rx_next;
  logic              tx_load;
  logic              tx_shift;
  logic [BYTE_W-1:0] tx_val;
  logic              drive;

  tws_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ce_i, sclk_i, sdio_i}),
    .q   (pin_s)
  );

  assign ce_s   = pin_s[2];
  assign sclk_s = pin_s[1];
  assign din_s  = pin_s[0];

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;

  tws_shifter u_shift (
    .clk      (clk),
    .rst      (rst),
    .rise     (sclk_rise),
    .din      (din_s),
    .load     (tx_load),
    .shift    (tx_shift),
    .load_val (tx_val),
    .rx_next  (rx_next),
    .dout     (sdio_o)
  );

  tws_ctrl #(.CLK_REGS(CLK_REGS), .RAM_BYTES(RAM_BYTES)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ce_s      (ce_s),
    .rise      (sclk_rise),
    .fall      (sclk_fall),
    .rx_next   (rx_next),
    .reg_rdata (reg_rdata),
    .tx_load   (tx_load),
    .tx_shift  (tx_shift),
    .tx_val    (tx_val),
    .drive     (drive),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
  );

  // raw enable gates the driver so the line is released with no sync delay
  assign sdio_oe = drive & ce_i;
endmodule

// File: rtl/tws_slave_chk.sv
module tws_slave_chk import tws_pkg::*; (
  input logic              clk,
  input logic              rst,
  input logic              ce_s,
  input logic              fall,
  input logic              drive,
  input logic              sdio_o,
  input logic              reg_we,
  input logic              reg_re,
  input logic [ADDR_W-1:0] reg_addr
);
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_re));

  assert_we_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !ce_s |=> (!reg_we && !drive));

  assert_dout_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(fall) |-> $stable(sdio_o));

  assert_drive_start_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(drive) |-> $past(fall));

  assert_ram_range_R7: assert property (@(posedge clk) disable iff (rst)
    ((reg_we || reg_re) && reg_addr[ADDR_W-1]) |-> (reg_addr[IDX_W-1:0] != '1));
endmodule

bind tws_slave tws_slave_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .ce_s     (ce_s),
  .fall     (sclk_fall),
  .drive    (drive),
  .sdio_o   (sdio_o),
  .reg_we   (reg_we),
  .reg_re   (reg_re),
  .reg_addr (reg_addr)
);

// File: tb/tws_slave_tb_top.sv
module tws_slave_tb_top;
  localparam int HP = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce = 1'b0;
  logic       sclk = 1'b0;
  logic       sdin = 1'b0;
  logic       sdio_o, sdio_oe, reg_we, reg_re;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata = 8'h00;

  logic [7:0] store [64];
  logic [7:0] expm  [64];
  int wr_cnt = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tws_slave dut_i (
    .clk(clk), .rst(rst), .ce_i(ce), .sclk_i(sclk), .sdio_i(sdin),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // storage model: registered read, one cycle latency
  always @(posedge clk) begin
    if (reg_we) begin
      store[reg_addr] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (reg_re) reg_rdata <= store[reg_addr];
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cmd_byte(input bit ok, input bit ram,
                                          input logic [4:0] a, input bit rd);
    return {ok, ram, a, rd};
  endfunction

  task automatic hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic xfer_begin();
    ce = 1'b1;
    hp();
  endtask

  task automatic xfer_end();
    hp();
    ce = 1'b0;
    hp();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sdin = b[i];
      hp();
      sclk = 1'b1;
      hp();
      sclk = 1'b0;
    end
  endtask

  task automatic recv_bits(output logic [7:0] b, input int n);
    b = '0;
    for (int i = 0; i < n; i++) begin
      hp();
      check("R5 oe during read bit", int'(sdio_oe), 1);
      b[i] = sdio_o;
      sclk = 1'b1;
      hp();
      check("R9 data held while sclk high", int'(sdio_o), int'(b[i]));
      sclk = 1'b0;
    end
  endtask

  task automatic wr_single(input bit ram, input logic [4:0] a, input logic [7:0] d);
    int w0;
    w0 = wr_cnt;
    xfer_begin();
    send_bits(cmd_byte(1, ram, a, 0), 8);
    send_bits(d, 8);
    xfer_end();
    expm[{ram, a}] = d;
    check("R4 single write strobe count (R10)", wr_cnt - w0, 1);
    check("R4/R2 single write stored", int'(store[{ram, a}]), int'(d));
  endtask

  task automatic rd_single(input bit ram, input logic [4:0] a);
    logic [7:0] got;
    xfer_begin();
    send_bits(cmd_byte(1, ram, a, 1), 8);
    recv_bits(got, 8);
    hp();
    check("R5 oe released after byte", int'(sdio_oe), 0);
    ce = 1'b0;
    hp();
    check("R5/R2 single read data", int'(got), int'(expm[{ram, a}]));
  endtask

  task automatic wr_burst(input bit ram, input int nbytes, input int extra);
    int w0;
    logic [7:0] d;
    w0 = wr_cnt;
    xfer_begin();
    send_bits(cmd_byte(1, ram, 5'h1f, 0), 8);
    for (int k = 0; k < nbytes + extra; k++) begin
      d = 8'($urandom());
      send_bits(d, 8);
      if (k < nbytes) expm[{ram, 5'(k)}] = d;
    end
    xfer_end();
    check(ram ? "R7 ram burst write count" : "R6 clock burst write count",
          wr_cnt - w0, nbytes);
    for (int k = 0; k < nbytes; k++)
      check(ram ? "R7 ram burst stored" : "R6 clock burst stored",
            int'(store[{ram, 5'(k)}]), int'(expm[{ram, 5'(k)}]));
  endtask

  task automatic rd_burst(input bit ram, input int nbytes);
    logic [7:0] got;
    xfer_begin();
    send_bits(cmd_byte(1, ram, 5'h1f, 1), 8);
    for (int k = 0; k < nbytes; k++) begin
      recv_bits(got, 8);
      check(ram ? "R7 ram burst read" : "R6 clock burst read",
            int'(got), int'(expm[{ram, 5'(k)}]));
    end
    hp();
    check(ram ? "R7 oe released after burst" : "R6 oe released after burst",
          int'(sdio_oe), 0);
    ce = 1'b0;
    hp();
  endtask

  initial begin
    int w0;
    logic [7:0] got;
    bit ram;
    logic [4:0] a;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 64; i++) begin
      store[i] = 8'h00;
      expm[i]  = 8'h00;
    end
    repeat (4) @(negedge clk);
    check("R1 oe in reset", int'(sdio_oe), 0);
    check("R1 we in reset", int'(reg_we), 0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    check("R1 oe idle", int'(sdio_oe), 0);
    check("R1 re idle", int'(reg_re), 0);

    // random single writes and reads
    for (int i = 0; i < 16; i++) begin
      ram = 1'($urandom());
      a = ram ? 5'($urandom_range(0, 30)) : 5'($urandom_range(0, 7));
      wr_single(ram, a, 8'($urandom()));
    end
    wr_single(1, 5'd30, 8'hA5);
    wr_single(0, 5'd0, 8'h5A);
    for (int i = 0; i < 12; i++) begin
      ram = 1'($urandom());
      a = ram ? 5'($urandom_range(0, 30)) : 5'($urandom_range(0, 7));
      rd_single(ram, a);
    end
    rd_single(1, 5'd30);

    // bursts: clock with one extra ignored byte, then RAM
    wr_burst(0, 8, 1);
    check("R6 extra burst byte ignored", int'(store[8]), int'(expm[8]));
    rd_burst(0, 8);
    wr_burst(1, 31, 0);
    rd_burst(1, 31);

    // invalid command: write and read
    w0 = wr_cnt;
    xfer_begin();
    send_bits(cmd_byte(0, 1, 5'd4, 0), 8);
    send_bits(8'h3C, 8);
    xfer_end();
    check("R3 invalid write no strobe", wr_cnt - w0, 0);
    check("R3 invalid write no change", int'(store[{1'b1, 5'd4}]), int'(expm[{1'b1, 5'd4}]));
    xfer_begin();
    send_bits(cmd_byte(0, 0, 5'd2, 1), 8);
    for (int i = 0; i < 8; i++) begin
      hp();
      check("R3 invalid read no drive", int'(sdio_oe), 0);
      sclk = 1'b1;
      hp();
      sclk = 1'b0;
    end
    xfer_end();

    // abort in the middle of a write byte
    w0 = wr_cnt;
    xfer_begin();
    send_bits(cmd_byte(1, 1, 5'd3, 0), 8);
    send_bits(~expm[{1'b1, 5'd3}], 5);
    ce = 1'b0;
    repeat (3 * HP) @(negedge clk);
    check("R8 partial byte not written", wr_cnt - w0, 0);
    check("R8 partial byte store intact", int'(store[{1'b1, 5'd3}]), int'(expm[{1'b1, 5'd3}]));

    // abort in the middle of a read byte
    xfer_begin();
    send_bits(cmd_byte(1, 1, 5'd30, 1), 8);
    recv_bits(got, 3);
    check("R8 partial read bits", int'(got[2:0]), int'(expm[{1'b1, 5'd30}] & 8'h07));
    ce = 1'b0;
    #1;
    check("R8 oe drops with enable", int'(sdio_oe), 0);
    repeat (3 * HP) @(negedge clk);

    // a normal transfer still works after aborts
    wr_single(1, 5'd7, 8'hC3);
    rd_single(1, 5'd7);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule